// File: doc/BRIEF.md
# Dual Posted Write Buffer

This block sits between a 64-bit CPU write channel and two downstream user ports. The CPU posts each write, either a single beat or a burst of up to four beats, into one of two 32-byte holding buffers. The block does not wait for the write to finish downstream. A finished buffer is offered to the user port named by the write's port id. That port empties it over a valid/ready drain interface, one 64-bit beat per handshake, with the byte enables and a per-beat address.

Both buffers are a shared pool, so either port can drain either buffer. While one buffer is held or being emptied by a port, the CPU side fills the other. A buffer goes back to the pool as soon as its last beat has been drained. When neither buffer can take a new write, the block holds the CPU off by dropping write-ready. Every CPU-side input is captured in a register stage before any allocation or storage logic uses it.

Top module: `dual_post_wbuf`

## Requirements
- R1: After reset, `wr_ready` is 1 and both bits of `dr_valid` are 0.
- R2: The write channel inputs are registered before use. For a single-beat write accepted at rising edge k, with the port idle, `dr_valid` stays 0 after edge k and becomes 1 after edge k+1.
- R3: A buffer holds at most 4 beats. A burst closes on the beat that has `wr_last`=1 or on its fourth beat, whichever comes first. A beat after a forced close starts a new buffer. The drain of a closed buffer asserts `dr_last` on its final beat only.
- R4: Each write takes a whole buffer, even a single beat. When both buffers hold writes that have not been drained, `wr_ready` is 0 and no further beat is taken. `wr_ready` returns to 1 once a buffer has been fully drained.
- R5: A buffer is not offered on any drain port until its last beat has been written. A partly filled burst leaves `dr_valid` at 0.
- R6: `wr_port`=0 sends the write to drain port 0, which uses bit 0 and the lowest slice of every `dr_*` vector. `wr_port`=1 sends it to port 1, which uses bit 1 and the upper slice. Either port can drain either buffer, and the two ports never present the same buffer.
- R7: Writes bound for the same port are drained in the order they were closed.
- R8: While one port holds a closed buffer without draining it, the CPU can fill the other buffer and the other port can drain it.
- R9: While `dr_valid` is 1 and `dr_ready` is 0 on a port, that port's data, byte enables, address and last flag stay unchanged.
- R10: Drain beat b of a buffer carries the data and byte enables of written beat b unchanged. Its `dr_addr` equals the address taken with the burst's first beat plus 8*b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Write beat can be taken this cycle |
| wr_addr | input | AW | Start address, used on the first beat of a burst |
| wr_data | input | DW | Write beat data |
| wr_be | input | DW/8 | Byte enables of the beat |
| wr_last | input | 1 | Final beat of the burst |
| wr_port | input | 1 | Destination drain port of the burst, taken on its first beat |
| dr_valid | output | 2 | Per port: a beat is offered |
| dr_ready | input | 2 | Per port: the beat is taken |
| dr_addr | output | 2*AW | Per port beat address, port p in slice p |
| dr_data | output | 2*DW | Per port beat data |
| dr_be | output | 2*DW/8 | Per port byte enables |
| dr_last | output | 2 | Per port: offered beat is the last of its buffer |

## Verification
The bench builds the block with its default parameters: 64-bit data, 32-bit addresses and four beats per buffer. At four beats per buffer, a fourth beat without a last flag forces a buffer to close. With only two buffers, two stalled single-beat writes are enough to reach the held-off state. Under these settings the short directed sequences can reach out-of-order port use, a full pool, same-port ordering and one port stalling while the other drains.

// File: rtl/dual_post_wbuf.sv
module dual_post_wbuf #(
  parameter int DW    = 64,
  parameter int AW    = 32,
  parameter int BEATS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [DW/8-1:0]     wr_be,
  input  logic                wr_last,
  input  logic                wr_port,
  output logic [1:0]          dr_valid,
  input  logic [1:0]          dr_ready,
  output logic [2*AW-1:0]     dr_addr,
  output logic [2*DW-1:0]     dr_data,
  output logic [2*(DW/8)-1:0] dr_be,
  output logic [1:0]          dr_last
);

  localparam int BW  = DW / 8;
  localparam int IW  = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int CW  = $clog2(BEATS + 1);
  localparam int BSH = $clog2(BW);

  typedef enum logic [1:0] {B_FREE, B_FILL, B_RDY} bst_t;

  bst_t            st   [2];
  logic [DW-1:0]   dat  [2][BEATS];
  logic [BW-1:0]   ben  [2][BEATS];
  logic [AW-1:0]   base [2];
  logic            dst  [2];
  logic [CW-1:0]   cnt  [2];
  logic [IW-1:0]   dptr [2];
  logic [IW-1:0]   fptr;
  logic            old_sel;

  logic            r_valid, r_last, r_port;
  logic [AW-1:0]   r_addr;
  logic [DW-1:0]   r_data;
  logic [BW-1:0]   r_be;

  logic            has_fill, fb, r_start, r_close, open_after;
  logic [IW-1:0]   fpos;
  logic [1:0]      nfree, psel, fire, dlast;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_valid <= 1'b0;
      r_last  <= 1'b0;
      r_port  <= 1'b0;
      r_addr  <= '0;
      r_data  <= '0;
      r_be    <= '0;
    end else begin
      r_valid <= wr_valid && wr_ready;
      r_last  <= wr_last;
      r_port  <= wr_port;
      r_addr  <= wr_addr;
      r_data  <= wr_data;
      r_be    <= wr_be;
    end

  assign has_fill   = (st[0] == B_FILL) || (st[1] == B_FILL);
  assign fb         = has_fill ? (st[1] == B_FILL) : (st[0] != B_FREE);
  assign fpos       = has_fill ? fptr : '0;
  assign r_start    = r_valid && !has_fill;
  assign r_close    = r_valid && (r_last || fpos == IW'(BEATS - 1));
  assign nfree      = 2'(st[0] == B_FREE) + 2'(st[1] == B_FREE);
  assign open_after = (has_fill || r_valid) && !r_close;
  assign wr_ready   = open_after || (nfree > {1'b0, r_start});

  genvar p;
  for (p = 0; p < 2; p++) begin : g_port
    logic [1:0] cand;
    assign cand = {st[1] == B_RDY && dst[1] == 1'(p),
                   st[0] == B_RDY && dst[0] == 1'(p)};
    assign psel[p]               = (&cand) ? old_sel : cand[1];
    assign dr_valid[p]           = |cand;
    assign fire[p]               = dr_valid[p] && dr_ready[p];
    assign dlast[p]              = (CW'(dptr[psel[p]]) + CW'(1)) == cnt[psel[p]];
    assign dr_last[p]            = dlast[p];
    assign dr_data[p*DW +: DW]   = dat[psel[p]][dptr[psel[p]]];
    assign dr_be[p*BW +: BW]     = ben[psel[p]][dptr[psel[p]]];
    assign dr_addr[p*AW +: AW]   = base[psel[p]] + (AW'(dptr[psel[p]]) << BSH);

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dr_valid[p] && !dr_ready[p] |=> dr_valid[p] && $stable(dr_data[p*DW +: DW])
        && $stable(dr_be[p*BW +: BW]) && $stable(dr_addr[p*AW +: AW]) && $stable(dr_last[p])); // R9
  end

  always_ff @(posedge clk)
    if (r_valid) begin
      dat[fb][fpos] <= r_data;
      ben[fb][fpos] <= r_be;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        st[i]   <= B_FREE;
        base[i] <= '0;
        dst[i]  <= 1'b0;
        cnt[i]  <= '0;
        dptr[i] <= '0;
      end
      fptr    <= '0;
      old_sel <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++)
        for (int q = 0; q < 2; q++)
          if (fire[q] && psel[q] == 1'(i)) begin
            if (dlast[q]) begin
              st[i]   <= B_FREE;
              dptr[i] <= '0;
            end else
              dptr[i] <= dptr[i] + IW'(1);
          end
      if (r_valid) begin
        if (r_start) begin
          base[fb] <= r_addr;
          dst[fb]  <= r_port;
        end
        if (r_close) begin
          st[fb]  <= B_RDY;
          cnt[fb] <= CW'(fpos) + CW'(1);
          fptr    <= '0;
          old_sel <= (st[~fb] == B_RDY) ? ~fb : fb;
        end else begin
          st[fb]  <= B_FILL;
          fptr    <= fpos + IW'(1);
        end
      end
    end

  AST_ONE_OPEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    !(st[0] == B_FILL && st[1] == B_FILL)); // R3
  AST_ROOM_FOR_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    r_start |-> nfree != 2'd0); // R4
  AST_SPLIT_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
    !(dr_valid == 2'b11 && psel[0] == psel[1])); // R6
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> dr_valid == 2'b00); // R1

endmodule

// File: tb/dual_post_wbuf_tb.sv
`timescale 1ns/1ps
module dual_post_wbuf_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_last = 1'b0, wr_port = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_be = '0;
  logic [1:0]  dr_valid, dr_last;
  logic [1:0]  dr_ready = 2'b00;
  logic [63:0] dr_addr;
  logic [127:0] dr_data;
  logic [15:0] dr_be;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_post_wbuf dut_i (.clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .wr_last(wr_last), .wr_port(wr_port),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr), .dr_data(dr_data),
    .dr_be(dr_be), .dr_last(dr_last));

  // {port, beats, start address, seed}
  localparam logic [51:0] VEC [6] = '{
    {1'b0, 3'd1, 32'h0000_1000, 16'h11A0},
    {1'b1, 3'd4, 32'h0000_2000, 16'h22B1},
    {1'b0, 3'd2, 32'h8000_0040, 16'h33C2},
    {1'b1, 3'd3, 32'hFFFF_FFE0, 16'h44D3},
    {1'b0, 3'd4, 32'h0000_0100, 16'h55E4},
    {1'b1, 3'd1, 32'h1234_5678, 16'h66F5}};

  function automatic logic [63:0] f_data(input logic [15:0] s, input int b, input logic [31:0] a);
    return {s, 16'(b), a ^ 32'(b * 32'h0101_0101)};
  endfunction
  function automatic logic [7:0] f_be(input logic [15:0] s, input int b);
    return s[7:0] + 8'(b * 37) + 8'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input bit port, input int b0, input int n, input logic [31:0] a,
                      input logic [15:0] s, input bit mark_last);
    for (int b = b0; b < n; b++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = f_data(s, b, a); wr_be = f_be(s, b);
      wr_last = mark_last && (b == n - 1); wr_port = port;
      while (!wr_ready) @(negedge clk);
    end
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  task automatic drain(input bit port, input int n, input logic [31:0] a,
                       input logic [15:0] s, input string req);
    dr_ready[port] = 1'b1;
    for (int b = 0; b < n; b++) begin
      int w = 0;
      while (!dr_valid[port] && w < 40) begin @(negedge clk); w++; end
      chk(dr_valid[port], req, 64'(dr_valid[port]), 64'd1);
      chk(dr_data[port*64 +: 64] == f_data(s, b, a), {req, " R10 data"}, dr_data[port*64 +: 64], f_data(s, b, a));
      chk(dr_be[port*8 +: 8] == f_be(s, b), {req, " R10 be"}, 64'(dr_be[port*8 +: 8]), 64'(f_be(s, b)));
      chk(dr_addr[port*32 +: 32] == a + 32'(8 * b), {req, " R10 addr"}, 64'(dr_addr[port*32 +: 32]), 64'(a + 32'(8 * b)));
      chk(dr_last[port] == (b == n - 1), {req, " R3 last"}, 64'(dr_last[port]), 64'(b == n - 1));
      @(negedge clk);
    end
    dr_ready[port] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    logic [63:0] held_d;
    logic [31:0] held_a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ready == 1'b1, "R1 ready", 64'(wr_ready), 64'd1);
    chk(dr_valid == 2'b00, "R1 valid", 64'(dr_valid), 64'd0);

    for (int v = 0; v < 6; v++) begin
      bit pt = VEC[v][51];
      int nb = int'(VEC[v][50:48]);
      send(pt, 0, nb, VEC[v][47:16], VEC[v][15:0], 1'b1);
      @(negedge clk);
      chk(dr_valid == (2'b01 << pt), "R6 port select", 64'(dr_valid), 64'(2'b01 << pt));
      drain(pt, nb, VEC[v][47:16], VEC[v][15:0], "R10 vector");
    end

    // R2: register stage latency
    send(1'b0, 0, 1, 32'h0000_0A00, 16'h7001, 1'b1);
    chk(dr_valid[0] == 1'b0, "R2 not yet", 64'(dr_valid[0]), 64'd0);
    @(negedge clk);
    chk(dr_valid[0] == 1'b1, "R2 offered", 64'(dr_valid[0]), 64'd1);
    drain(1'b0, 1, 32'h0000_0A00, 16'h7001, "R2");

    // R5: partial burst hidden
    send(1'b0, 0, 3, 32'h0000_0B00, 16'h7102, 1'b0);
    repeat (3) @(negedge clk);
    chk(dr_valid == 2'b00, "R5 partial hidden", 64'(dr_valid), 64'd0);
    send(1'b0, 3, 4, 32'h0000_0B00, 16'h7102, 1'b1);
    @(negedge clk);
    chk(dr_valid == 2'b01, "R5 offered after last", 64'(dr_valid), 64'd1);
    drain(1'b0, 4, 32'h0000_0B00, 16'h7102, "R5");

    // R3: forced close on fourth beat, following beat starts a new buffer
    send(1'b1, 0, 4, 32'h0000_0C00, 16'h7203, 1'b0);
    send(1'b1, 0, 1, 32'h0000_0D00, 16'h7304, 1'b1);
    @(negedge clk);
    drain(1'b1, 4, 32'h0000_0C00, 16'h7203, "R3 forced close");
    drain(1'b1, 1, 32'h0000_0D00, 16'h7304, "R3 next buffer");

    // R4 / R7: single beats fill whole buffers, order kept on a port
    send(1'b1, 0, 1, 32'h0000_0E00, 16'h7405, 1'b1);
    send(1'b1, 0, 1, 32'h0000_0E40, 16'h7506, 1'b1);
    chk(wr_ready == 1'b0, "R4 held off", 64'(wr_ready), 64'd0);
    fork
      send(1'b0, 0, 1, 32'h0000_0F00, 16'h7607, 1'b1);
      begin
        repeat (3) @(negedge clk);
        chk(wr_ready == 1'b0, "R4 still held", 64'(wr_ready), 64'd0);
        chk(dr_valid == 2'b10, "R4 third not taken", 64'(dr_valid), 64'd2);
        drain(1'b1, 1, 32'h0000_0E00, 16'h7405, "R7 first");
        chk(wr_ready == 1'b1, "R4 ready back", 64'(wr_ready), 64'd1);
      end
    join
    drain(1'b1, 1, 32'h0000_0E40, 16'h7506, "R7 second");
    drain(1'b0, 1, 32'h0000_0F00, 16'h7607, "R4 third");

    // R8 / R9: port 0 stalled while CPU fills and port 1 drains
    send(1'b0, 0, 4, 32'h0000_1100, 16'h7708, 1'b1);
    @(negedge clk);
    held_d = dr_data[63:0];
    held_a = dr_addr[31:0];
    @(negedge clk);
    chk(dr_data[63:0] == held_d, "R9 data held", dr_data[63:0], held_d);
    chk(dr_addr[31:0] == held_a, "R9 addr held", 64'(dr_addr[31:0]), 64'(held_a));
    send(1'b1, 0, 4, 32'h0000_1200, 16'h7809, 1'b1);
    @(negedge clk);
    chk(dr_valid == 2'b11, "R8 both offered", 64'(dr_valid), 64'd3);
    drain(1'b1, 4, 32'h0000_1200, 16'h7809, "R8");
    chk(dr_valid[0] == 1'b1 && dr_data[63:0] == held_d, "R9 still held", dr_data[63:0], held_d);
    drain(1'b0, 4, 32'h0000_1100, 16'h7708, "R9");

    repeat (2) @(negedge clk);
    chk(dr_valid == 2'b00 && wr_ready, "R4 idle at end", 64'({dr_valid, wr_ready}), 64'd1);
    finish_run();
  end
endmodule